// File: doc/BRIEF.md
# Serial Bus Gap Count Controller

This block holds the gap count and the root-holdoff flag of one physical-layer node on a serial bus. Both values can be loaded in two ways: from a write to the node's first control register, or from a configuration packet that the node has sent or received. A short history of bus resets decides whether a reset leaves the gap count alone or sets it back to its maximum. The rule is that the gap count goes back to its maximum only after two bus resets in a row with no gap update between them. The single reset that normally follows a configuration update therefore keeps the newly loaded value on every node.

A register write that sets the initiate-reset bit also sends a one-cycle bus-reset request to the rest of the physical layer. The write itself counts as the gap update, so the reset it triggers keeps the value that was written. The current flag and gap count can be read back through a register image. In that image the initiate-reset bit always reads as zero.

Top module: `gap_count_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `gap_cnt` is 63 (all ones), `root_hold` is 0, `bus_rst_req` is 0, and the reset history is empty.
- R2: A register write (`reg_wr_en` high) loads `root_hold` from data bit 7 and `gap_cnt` from data bits 5:0, visible in the next cycle. It also clears the reset history, so that a later single bus reset keeps the loaded value.
- R3: A configuration packet strobe (`pkt_vld` high) loads `root_hold` from `pkt_rhb` and `gap_cnt` from `pkt_gap` in the next cycle, and clears the reset history.
- R4: When a register write and a packet strobe arrive in the same cycle, the register write's values are the ones loaded.
- R5: A bus reset (`bus_rst_evt` high) with an empty history leaves `gap_cnt` and `root_hold` unchanged and records the reset.
- R6: A second bus reset with no update since the previous one sets `gap_cnt` to 63 in the next cycle and leaves `root_hold` unchanged.
- R7: When an update and a bus reset arrive in the same cycle, the update's values are loaded, and that reset counts as the first reset after the update. The next lone bus reset then sets `gap_cnt` to 63.
- R8: A register write with data bit 6 set drives `bus_rst_req` high for exactly the one cycle after the write. A write with bit 6 clear raises no request.
- R9: `reg_rd_data` is {`root_hold`, 0, `gap_cnt`}. Bit 6 always reads 0.
- R10: The bus reset that follows a write with bit 6 set keeps the gap count that the write loaded.
- R11: In a cycle with no write, no packet and no bus reset, `gap_cnt` and `root_hold` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Write strobe for the control register |
| reg_wr_data | input | 8 | Write data: bit 7 root-holdoff, bit 6 initiate reset, bits 5:0 gap |
| pkt_vld | input | 1 | Configuration packet sent or received |
| pkt_rhb | input | 1 | Root-holdoff value carried by the packet |
| pkt_gap | input | 6 | Gap count carried by the packet |
| bus_rst_evt | input | 1 | One-cycle pulse: a bus reset occurred |
| root_hold | output | 1 | Current root-holdoff flag |
| gap_cnt | output | 6 | Current gap count |
| reg_rd_data | output | 8 | Register read-back image |
| bus_rst_req | output | 1 | One-cycle bus-reset request |

## Verification
The reset history is a single hidden bit, and it shows at the ports only through the next bus reset. If the bit is stuck clear, the gap count never returns to 63. If it is stuck set, the first reset after an update already sets the gap count to 63. Either fault is therefore visible one cycle after the first or second reset following an update. The bench sweeps every gap value through both load paths, and after each load it applies two resets and checks the gap count one cycle after each. Same-cycle collisions and the request pulse are checked one cycle after the stimulus.

// File: rtl/gcc_pkg.sv
package gcc_pkg;
  localparam int GAP_W_DEF = 6;
  localparam int RHB_BIT   = 7;
  localparam int IBR_BIT   = 6;

  typedef enum logic [1:0] {
    UPD_NONE = 2'd0,
    UPD_REG  = 2'd1,
    UPD_PKT  = 2'd2
  } upd_src_e;
endpackage

// File: rtl/gcc_upd_sel.sv
module gcc_upd_sel
  import gcc_pkg::*;
#(
  parameter int GAP_W = GAP_W_DEF,
  localparam int REG_W = GAP_W + 2
) (
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wr_data,
  input  logic             pkt_vld,
  input  logic             pkt_rhb,
  input  logic [GAP_W-1:0] pkt_gap,
  output upd_src_e         upd_src,
  output logic             upd_vld,
  output logic             upd_rhb,
  output logic [GAP_W-1:0] upd_gap,
  output logic             ibr_hit
);
  // A register write takes priority over a packet in the same cycle
  always_comb begin
    upd_src = UPD_NONE;
    upd_rhb = 1'b0;
    upd_gap = '0;
    if (reg_wr_en) begin
      upd_src = UPD_REG;
      upd_rhb = reg_wr_data[REG_W-1];
      upd_gap = reg_wr_data[GAP_W-1:0];
    end else if (pkt_vld) begin
      upd_src = UPD_PKT;
      upd_rhb = pkt_rhb;
      upd_gap = pkt_gap;
    end
  end

  assign upd_vld = (upd_src != UPD_NONE);
  assign ibr_hit = reg_wr_en & reg_wr_data[REG_W-2];
endmodule

// File: rtl/gcc_rst_hist.sv
module gcc_rst_hist (
  input  logic clk,
  input  logic rst,
  input  logic upd_vld,
  input  logic bus_rst_evt,
  output logic force_max
);
  logic armed;

  // A reset seen while armed, with no update in the same cycle, forces max
  assign force_max = bus_rst_evt & armed & ~upd_vld;

  always_ff @(posedge clk) begin
    if (rst)
      armed <= 1'b0;
    else if (bus_rst_evt)
      armed <= 1'b1;
    else if (upd_vld)
      armed <= 1'b0;
  end
endmodule

// File: rtl/gcc_state.sv
module gcc_state #(
  parameter int GAP_W = 6,
  localparam logic [GAP_W-1:0] GAP_MAX = {GAP_W{1'b1}}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_vld,
  input  logic             upd_rhb,
  input  logic [GAP_W-1:0] upd_gap,
  input  logic             force_max,
  input  logic             ibr_hit,
  output logic             root_hold,
  output logic [GAP_W-1:0] gap_cnt,
  output logic             bus_rst_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt     <= GAP_MAX;
      root_hold   <= 1'b0;
      bus_rst_req <= 1'b0;
    end else begin
      bus_rst_req <= ibr_hit;
      if (upd_vld) begin
        gap_cnt   <= upd_gap;
        root_hold <= upd_rhb;
      end else if (force_max) begin
        gap_cnt   <= GAP_MAX;
      end
    end
  end
endmodule

// File: rtl/gap_count_ctrl.sv
module gap_count_ctrl
  import gcc_pkg::*;
#(
  parameter int GAP_W = GAP_W_DEF,
  localparam int REG_W = GAP_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wr_data,
  input  logic             pkt_vld,
  input  logic             pkt_rhb,
  input  logic [GAP_W-1:0] pkt_gap,
  input  logic             bus_rst_evt,
  output logic             root_hold,
  output logic [GAP_W-1:0] gap_cnt,
  output logic [REG_W-1:0] reg_rd_data,
  output logic             bus_rst_req
);
  upd_src_e         upd_src;
  logic             upd_vld;
  logic             upd_rhb;
  logic [GAP_W-1:0] upd_gap;
  logic             ibr_hit;
  logic             force_max;

  gcc_upd_sel #(.GAP_W(GAP_W)) u_sel (
    .reg_wr_en   (reg_wr_en),
    .reg_wr_data (reg_wr_data),
    .pkt_vld     (pkt_vld),
    .pkt_rhb     (pkt_rhb),
    .pkt_gap     (pkt_gap),
    .upd_src     (upd_src),
    .upd_vld     (upd_vld),
    .upd_rhb     (upd_rhb),
    .upd_gap     (upd_gap),
    .ibr_hit     (ibr_hit)
  );

  gcc_rst_hist u_hist (
    .clk         (clk),
    .rst         (rst),
    .upd_vld     (upd_vld),
    .bus_rst_evt (bus_rst_evt),
    .force_max   (force_max)
  );

  gcc_state #(.GAP_W(GAP_W)) u_state (
    .clk         (clk),
    .rst         (rst),
    .upd_vld     (upd_vld),
    .upd_rhb     (upd_rhb),
    .upd_gap     (upd_gap),
    .force_max   (force_max),
    .ibr_hit     (ibr_hit),
    .root_hold   (root_hold),
    .gap_cnt     (gap_cnt),
    .bus_rst_req (bus_rst_req)
  );

  // Read-back image: initiate-reset bit always reads as zero
  assign reg_rd_data = {root_hold, 1'b0, gap_cnt};
endmodule

// File: rtl/gap_count_ctrl_chk.sv
module gap_count_ctrl_chk #(
  parameter int GAP_W = 6,
  localparam int REG_W = GAP_W + 2,
  localparam logic [GAP_W-1:0] GAP_MAX = {GAP_W{1'b1}}
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr_en,
  input logic [REG_W-1:0] reg_wr_data,
  input logic             pkt_vld,
  input logic             pkt_rhb,
  input logic [GAP_W-1:0] pkt_gap,
  input logic             bus_rst_evt,
  input logic             root_hold,
  input logic [GAP_W-1:0] gap_cnt,
  input logic [REG_W-1:0] reg_rd_data,
  input logic             bus_rst_req
);
  logic any_upd;
  logic m_armed;
  assign any_upd = reg_wr_en | pkt_vld;

  always_ff @(posedge clk) begin
    if (rst) m_armed <= 1'b0;
    else if (bus_rst_evt) m_armed <= 1'b1;
    else if (any_upd) m_armed <= 1'b0;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (gap_cnt == GAP_MAX && !root_hold && !bus_rst_req));

  // R2
  wr_load_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |=> (gap_cnt == $past(reg_wr_data[GAP_W-1:0]) &&
                   root_hold == $past(reg_wr_data[REG_W-1])));

  // R3
  pkt_load_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_vld && !reg_wr_en) |=> (gap_cnt == $past(pkt_gap) && root_hold == $past(pkt_rhb)));

  // R5
  first_rst_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rst_evt && !m_armed && !any_upd) |=> ($stable(gap_cnt) && $stable(root_hold)));

  // R6
  second_rst_max_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rst_evt && m_armed && !any_upd) |=> (gap_cnt == GAP_MAX && $stable(root_hold)));

  // R8
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && reg_wr_data[REG_W-2]) |=> bus_rst_req);

  // R8
  req_cause_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rst_req |-> $past(reg_wr_en && reg_wr_data[REG_W-2]));

  // R9
  rd_ibr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_rd_data[REG_W-2] && reg_rd_data[GAP_W-1:0] == gap_cnt);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!any_upd && !bus_rst_evt) |=> ($stable(gap_cnt) && $stable(root_hold)));
endmodule

bind gap_count_ctrl gap_count_ctrl_chk #(.GAP_W(GAP_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_data (reg_wr_data),
  .pkt_vld     (pkt_vld),
  .pkt_rhb     (pkt_rhb),
  .pkt_gap     (pkt_gap),
  .bus_rst_evt (bus_rst_evt),
  .root_hold   (root_hold),
  .gap_cnt     (gap_cnt),
  .reg_rd_data (reg_rd_data),
  .bus_rst_req (bus_rst_req)
);

// File: tb/gap_count_ctrl_tb.sv
`timescale 1ns/1ps
module gap_count_ctrl_tb;
  localparam int GAP_W = 6;
  localparam int REG_W = GAP_W + 2;
  localparam int MAXV  = (1 << GAP_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             reg_wr_en = 1'b0;
  logic [REG_W-1:0] reg_wr_data = '0;
  logic             pkt_vld = 1'b0;
  logic             pkt_rhb = 1'b0;
  logic [GAP_W-1:0] pkt_gap = '0;
  logic             bus_rst_evt = 1'b0;
  logic             root_hold;
  logic [GAP_W-1:0] gap_cnt;
  logic [REG_W-1:0] reg_rd_data;
  logic             bus_rst_req;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  gap_count_ctrl #(.GAP_W(GAP_W)) u_dut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .pkt_vld(pkt_vld), .pkt_rhb(pkt_rhb), .pkt_gap(pkt_gap),
    .bus_rst_evt(bus_rst_evt), .root_hold(root_hold), .gap_cnt(gap_cnt),
    .reg_rd_data(reg_rd_data), .bus_rst_req(bus_rst_req)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Advance one edge; inputs then outputs are settled 1 ns after it
  task automatic tick();
    @(posedge clk);
    #1;
    reg_wr_en = 1'b0; pkt_vld = 1'b0; bus_rst_evt = 1'b0;
  endtask

  task automatic do_wr(input bit r, input bit ibr, input int g);
    reg_wr_en = 1'b1;
    reg_wr_data = {r, ibr, GAP_W'(g)};
  endtask

  task automatic do_pkt(input bit r, input int g);
    pkt_vld = 1'b1; pkt_rhb = r; pkt_gap = GAP_W'(g);
  endtask

  initial begin
    repeat (3) tick();
    // R1 during reset
    check("R1 gap", int'(gap_cnt), MAXV);
    check("R1 rhb", int'(root_hold), 0);
    check("R1 req", int'(bus_rst_req), 0);
    rst = 1'b0;
    tick();
    check("R1 gap after release", int'(gap_cnt), MAXV);

    // R2 R9 R5 R6: sweep every gap value through the register path
    for (int g = 0; g <= MAXV; g++) begin
      bit r = g[0];
      do_wr(r, 1'b0, g); tick();
      check("R2 gap", int'(gap_cnt), g);
      check("R2 rhb", int'(root_hold), int'(r));
      check("R9 readback", int'(reg_rd_data), (int'(r) << 7) | g);
      check("R8 no req", int'(bus_rst_req), 0);
      bus_rst_evt = 1'b1; tick();
      check("R5 first reset keeps", int'(gap_cnt), g);
      bus_rst_evt = 1'b1; tick();
      check("R6 second reset max", int'(gap_cnt), MAXV);
      check("R6 rhb kept", int'(root_hold), int'(r));
    end

    // R3: sweep through the packet path
    for (int g = 0; g <= MAXV; g++) begin
      bit r = ~g[0];
      do_pkt(r, g); tick();
      check("R3 gap", int'(gap_cnt), g);
      check("R3 rhb", int'(root_hold), int'(r));
      bus_rst_evt = 1'b1; tick();
      check("R3 R5 keep", int'(gap_cnt), g);
      bus_rst_evt = 1'b1; tick();
      check("R3 R6 max", int'(gap_cnt), MAXV);
    end

    // R8 R10: initiate-reset write
    do_wr(1'b1, 1'b1, 10); tick();
    check("R8 req pulse", int'(bus_rst_req), 1);
    check("R9 ibr reads 0", int'(reg_rd_data[6]), 0);
    check("R8 gap", int'(gap_cnt), 10);
    tick();
    check("R8 req one cycle", int'(bus_rst_req), 0);
    bus_rst_evt = 1'b1; tick();
    check("R10 reset after ibr keeps", int'(gap_cnt), 10);
    bus_rst_evt = 1'b1; tick();
    check("R10 then max", int'(gap_cnt), MAXV);

    // R4: write beats packet
    do_wr(1'b0, 1'b0, 7); do_pkt(1'b1, 20); tick();
    check("R4 gap", int'(gap_cnt), 7);
    check("R4 rhb", int'(root_hold), 0);

    // R7: update with reset in same cycle
    do_wr(1'b1, 1'b0, 9); bus_rst_evt = 1'b1; tick();
    check("R7 update applied", int'(gap_cnt), 9);
    bus_rst_evt = 1'b1; tick();
    check("R7 next reset max", int'(gap_cnt), MAXV);
    do_pkt(1'b0, 33); bus_rst_evt = 1'b1; tick();
    check("R7 pkt applied", int'(gap_cnt), 33);
    bus_rst_evt = 1'b1; tick();
    check("R7 pkt next reset max", int'(gap_cnt), MAXV);

    // R2: intervening write clears history
    do_wr(1'b0, 1'b0, 12); tick();
    bus_rst_evt = 1'b1; tick();
    do_wr(1'b0, 1'b0, 13); tick();
    bus_rst_evt = 1'b1; tick();
    check("R2 history cleared", int'(gap_cnt), 13);

    // R11: idle cycles hold
    repeat (4) tick();
    check("R11 hold gap", int'(gap_cnt), 13);
    check("R11 hold rhb", int'(root_hold), 0);
    check("R8 idle no req", int'(bus_rst_req), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule